// File: doc/BRIEF.md
# Overlapped-Fetch Accumulator Core

This block is a small 8-bit processor core that runs a narrow slice of a classic accumulator instruction set: load-immediate into the accumulator, store to a zero-page address, store to a 16-bit absolute address, and absolute jump. It drives a single memory port that carries one access per clock. The memory answers a read within the same cycle, and a write lands at the clock edge that ends the write cycle. Every bus cycle, and every instruction as it completes, is also reported on a trace port for an external observer.

The core overlaps work. The opcode of the next instruction is read in the same cycle in which the current instruction finishes, and that cycle counts as the retire cycle. Each store spends one dummy read before its write. An external debug monitor controls execution through a run level and a single-step pulse. Because the next opcode is already held inside the core when it halts, a halt always lands on an instruction boundary, and the held opcode is not read again when execution resumes.

Top module: `acc_core`

## Requirements
- R1: After reset the core reads the low PC byte from address $FFFC and the high byte from $FFFD, then reads the first opcode at that little-endian address.
- R2: Opcode $A9 takes two bus cycles: it reads the operand at PC+1, then reads the next opcode at PC+2. The operand is in the accumulator after the second cycle.
- R3: A load sets status bit 7 (N) to bit 7 of the value and sets status bit 1 (Z) when the value is zero. All other status bits keep their values.
- R4: Opcode $85 runs as four cycles: read the operand byte, read that same operand address again as a dummy, write the accumulator to address $00nn, then read the next opcode.
- R5: Opcode $8D reads a low address byte and then a high address byte. It repeats the read of the high-byte address as a dummy, writes the accumulator to the little-endian address, then reads the next opcode.
- R6: Opcode $4C reads a low target byte and a high target byte. The next opcode is then read from the little-endian target address.
- R7: The cycle that reads the next opcode is the retire cycle of the current instruction. That opcode is never read a second time, even when a halt falls in between.
- R8: The trace reports every bus cycle with a valid strobe, a write flag, the address and the data byte (the read data, or the written data). On a retire cycle it also raises a retire strobe and gives the address of the retiring opcode.
- R9: While the run input is low, the core halts after the current instruction retires and makes no bus cycles. A step pulse given while the core is halted runs exactly one instruction and then halts again.
- R10: An opcode outside the four above sets a sticky illegal flag and halts the core without any bus cycle. Run and step then have no effect until reset.
- R11: Reset clears A, X, Y and Z, sets the 16-bit stack pointer to $01FF, and sets the status byte to $24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory address of the current bus cycle |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable, takes effect at the clock edge |
| dbg_run | input | 1 | Run level from the debug monitor |
| dbg_step | input | 1 | Single-step pulse, used while halted |
| dbg_halted | output | 1 | Core halted at an instruction boundary |
| dbg_illegal | output | 1 | Sticky illegal-opcode flag |
| dbg_a | output | 8 | Accumulator |
| dbg_x | output | 8 | X index register |
| dbg_y | output | 8 | Y index register |
| dbg_z | output | 8 | Z index register |
| dbg_p | output | 8 | Status byte |
| dbg_sp | output | 16 | Stack pointer |
| trc_valid | output | 1 | A bus cycle occurs this clock |
| trc_write | output | 1 | The bus cycle is a write |
| trc_addr | output | 16 | Bus cycle address |
| trc_data | output | 8 | Bus cycle data byte |
| trc_retire | output | 1 | An instruction retires this clock |
| trc_pc | output | 16 | Opcode address of the retiring instruction |

## Verification
The test program loads zero, a negative value and a positive value, so that every combination of the N and Z results appears. It stores both through a zero-page address and through an absolute address whose bytes differ, which exposes swapped or truncated address bytes. A jump to another page shows that the next opcode is read from the target and not from the next sequential address. The first two instructions are single-stepped and the rest run freely, so both the halt path and the run path are driven against the same expected bus sequence. The program ends on an unknown opcode, and the bench then toggles run and step to show that neither has any effect.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam logic [AW-1:0] VEC_ADDR = 16'hFFFC;
    localparam logic [AW-1:0] SP_INIT  = 16'h01FF;
    localparam logic [DW-1:0] P_INIT   = 8'h24;
    localparam int P_NEG  = DW - 1;
    localparam int P_ZERO = 1;

    localparam logic [DW-1:0] OPC_LDI = 8'hA9;
    localparam logic [DW-1:0] OPC_STZ = 8'h85;
    localparam logic [DW-1:0] OPC_STA = 8'h8D;
    localparam logic [DW-1:0] OPC_JMP = 8'h4C;

    typedef enum logic [3:0] {
        S_VLO, S_VHI, S_FETCH, S_OP1, S_OP2,
        S_DUMMY, S_WRITE, S_LAST, S_HALT, S_DEAD
    } state_t;

    typedef enum logic [1:0] { K_LDI, K_STZ, K_STA, K_JMP } kind_t;

    typedef struct packed {
        logic  legal;
        kind_t kind;
    } dec_t;

    typedef struct packed {
        logic          valid;
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_t;

    function automatic dec_t decode(input logic [DW-1:0] op);
        dec_t d;
        d.legal = 1'b1;
        d.kind  = K_LDI;
        case (op)
            OPC_LDI: d.kind = K_LDI;
            OPC_STZ: d.kind = K_STZ;
            OPC_STA: d.kind = K_STA;
            OPC_JMP: d.kind = K_JMP;
            default: d.legal = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic [DW-1:0] nz_apply(input logic [DW-1:0] p,
                                               input logic [DW-1:0] v);
        logic [DW-1:0] r;
        r         = p;
        r[P_NEG]  = v[DW-1];
        r[P_ZERO] = (v == '0);
        return r;
    endfunction

endpackage

// File: rtl/acc_core_regs.sv
module acc_core_regs
    import acc_core_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          a_load,
    input  logic [DW-1:0] a_data,
    output logic [DW-1:0] a_q,
    output logic [DW-1:0] x_q,
    output logic [DW-1:0] y_q,
    output logic [DW-1:0] z_q,
    output logic [DW-1:0] p_q,
    output logic [AW-1:0] sp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            x_q  <= '0;
            y_q  <= '0;
            z_q  <= '0;
            p_q  <= P_INIT;
            sp_q <= SP_INIT;
        end else if (a_load) begin
            a_q <= a_data;
            p_q <= nz_apply(p_q, a_data);
        end
    end

    // R3: only N and Z may move
    a_r3_other_bits_kept: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(p_q[6:2]) && $stable(p_q[0])));

    // R2: a load request shows up in the accumulator one edge later
    a_r2_acc_loaded: assert property (@(posedge clk) disable iff (rst)
        a_load |=> (a_q == $past(a_data)));

endmodule

// File: rtl/acc_core_seq.sv
module acc_core_seq
    import acc_core_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          step,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] acc,
    output bus_t          bus,
    output logic          retire,
    output logic [AW-1:0] ipc,
    output logic          a_load,
    output logic [DW-1:0] a_data,
    output logic          halted,
    output logic          illegal
);

    state_t        state_q, state_d;
    logic [AW-1:0] pc_q, ipc_q, ea_q, last_q;
    logic [DW-1:0] ir_q, opnd_q;
    logic          ill_q;
    dec_t          dec;

    assign dec = decode(ir_q);

    always_comb begin
        bus     = '0;
        retire  = 1'b0;
        state_d = state_q;
        case (state_q)
            S_VLO: begin
                bus.valid = 1'b1;
                bus.addr  = VEC_ADDR;
                state_d   = S_VHI;
            end
            S_VHI: begin
                bus.valid = 1'b1;
                bus.addr  = VEC_ADDR + 1'b1;
                state_d   = S_FETCH;
            end
            S_FETCH: begin
                bus.valid = 1'b1;
                bus.addr  = pc_q;
                state_d   = run ? S_OP1 : S_HALT;
            end
            S_OP1: begin
                if (!dec.legal) begin
                    state_d = S_DEAD;
                end else begin
                    bus.valid = 1'b1;
                    bus.addr  = pc_q;
                    case (dec.kind)
                        K_LDI:   state_d = S_LAST;
                        K_STZ:   state_d = S_DUMMY;
                        default: state_d = S_OP2;
                    endcase
                end
            end
            S_OP2: begin
                bus.valid = 1'b1;
                bus.addr  = pc_q;
                state_d   = (dec.kind == K_JMP) ? S_LAST : S_DUMMY;
            end
            S_DUMMY: begin
                bus.valid = 1'b1;
                bus.addr  = last_q;
                state_d   = S_WRITE;
            end
            S_WRITE: begin
                bus.valid = 1'b1;
                bus.write = 1'b1;
                bus.addr  = ea_q;
                bus.wdata = acc;
                state_d   = S_LAST;
            end
            S_LAST: begin
                bus.valid = 1'b1;
                bus.addr  = pc_q;
                retire    = 1'b1;
                state_d   = run ? S_OP1 : S_HALT;
            end
            S_HALT: state_d = (run || step) ? S_OP1 : S_HALT;
            default: state_d = S_DEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_VLO;
            pc_q    <= '0;
            ipc_q   <= '0;
            ea_q    <= '0;
            last_q  <= '0;
            ir_q    <= '0;
            opnd_q  <= '0;
            ill_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (bus.valid && !bus.write)
                last_q <= bus.addr;
            case (state_q)
                S_VLO: pc_q[DW-1:0]  <= rdata;
                S_VHI: pc_q[AW-1:DW] <= rdata;
                S_FETCH, S_LAST: begin
                    ir_q  <= rdata;
                    ipc_q <= pc_q;
                    pc_q  <= pc_q + 1'b1;
                end
                S_OP1: begin
                    if (dec.legal) begin
                        pc_q   <= pc_q + 1'b1;
                        opnd_q <= rdata;
                        ea_q   <= {{(AW-DW){1'b0}}, rdata};
                    end else begin
                        ill_q <= 1'b1;
                    end
                end
                S_OP2: begin
                    if (dec.kind == K_JMP) begin
                        pc_q <= {rdata, ea_q[DW-1:0]};
                    end else begin
                        pc_q <= pc_q + 1'b1;
                        ea_q <= {rdata, ea_q[DW-1:0]};
                    end
                end
                default: ;
            endcase
        end
    end

    assign ipc     = ipc_q;
    assign a_load  = (state_q == S_LAST) && dec.legal && (dec.kind == K_LDI);
    assign a_data  = opnd_q;
    assign halted  = (state_q == S_HALT) || (state_q == S_DEAD);
    assign illegal = ill_q;

    // R4: every write is preceded by a read cycle (the dummy read)
    a_r4_dummy_before_write: assert property (@(posedge clk) disable iff (rst)
        bus.write |-> ($past(bus.valid) && !$past(bus.write)));

    // R10: illegal flag is sticky
    a_r10_illegal_sticky: assert property (@(posedge clk) disable iff (rst)
        ill_q |=> ill_q);

    // R10: no bus activity once illegal
    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        ill_q |-> !bus.valid);

endmodule

// File: rtl/acc_core_trace.sv
module acc_core_trace
    import acc_core_pkg::*;
(
    input  bus_t          bus,
    input  logic [DW-1:0] rdata,
    input  logic          retire,
    input  logic [AW-1:0] ipc,
    output logic          trc_valid,
    output logic          trc_write,
    output logic [AW-1:0] trc_addr,
    output logic [DW-1:0] trc_data,
    output logic          trc_retire,
    output logic [AW-1:0] trc_pc
);

    always_comb begin
        trc_valid  = bus.valid;
        trc_write  = bus.write;
        trc_addr   = bus.addr;
        trc_data   = bus.write ? bus.wdata : rdata;
        trc_retire = retire;
        trc_pc     = retire ? ipc : '0;
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic          dbg_run,
    input  logic          dbg_step,
    output logic          dbg_halted,
    output logic          dbg_illegal,
    output logic [DW-1:0] dbg_a,
    output logic [DW-1:0] dbg_x,
    output logic [DW-1:0] dbg_y,
    output logic [DW-1:0] dbg_z,
    output logic [DW-1:0] dbg_p,
    output logic [AW-1:0] dbg_sp,
    output logic          trc_valid,
    output logic          trc_write,
    output logic [AW-1:0] trc_addr,
    output logic [DW-1:0] trc_data,
    output logic          trc_retire,
    output logic [AW-1:0] trc_pc
);

    bus_t          bus;
    logic          retire, a_load;
    logic [AW-1:0] ipc;
    logic [DW-1:0] a_data;

    acc_core_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .run     (dbg_run),
        .step    (dbg_step),
        .rdata   (mem_rdata),
        .acc     (dbg_a),
        .bus     (bus),
        .retire  (retire),
        .ipc     (ipc),
        .a_load  (a_load),
        .a_data  (a_data),
        .halted  (dbg_halted),
        .illegal (dbg_illegal)
    );

    acc_core_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .a_load (a_load),
        .a_data (a_data),
        .a_q    (dbg_a),
        .x_q    (dbg_x),
        .y_q    (dbg_y),
        .z_q    (dbg_z),
        .p_q    (dbg_p),
        .sp_q   (dbg_sp)
    );

    acc_core_trace u_trace (
        .bus        (bus),
        .rdata      (mem_rdata),
        .retire     (retire),
        .ipc        (ipc),
        .trc_valid  (trc_valid),
        .trc_write  (trc_write),
        .trc_addr   (trc_addr),
        .trc_data   (trc_data),
        .trc_retire (trc_retire),
        .trc_pc     (trc_pc)
    );

    assign mem_addr  = bus.addr;
    assign mem_wdata = bus.wdata;
    assign mem_we    = bus.write;

    // R8: a retire cycle is always the read of the next opcode
    a_r8_retire_is_read: assert property (@(posedge clk) disable iff (rst)
        trc_retire |-> (trc_valid && !trc_write));

    // R9: a halted core keeps the bus idle
    a_r9_halted_quiet: assert property (@(posedge clk) disable iff (rst)
        dbg_halted |-> !trc_valid);

endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        dbg_run = 1'b0;
    logic        dbg_step = 1'b0;
    logic        dbg_halted, dbg_illegal;
    logic [7:0]  dbg_a, dbg_x, dbg_y, dbg_z, dbg_p;
    logic [15:0] dbg_sp;
    logic        trc_valid, trc_write, trc_retire;
    logic [15:0] trc_addr, trc_pc;
    logic [7:0]  trc_data;

    always #10 clk = ~clk;

    acc_core u_dut (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .dbg_run(dbg_run), .dbg_step(dbg_step), .dbg_halted(dbg_halted), .dbg_illegal(dbg_illegal),
        .dbg_a(dbg_a), .dbg_x(dbg_x), .dbg_y(dbg_y), .dbg_z(dbg_z), .dbg_p(dbg_p), .dbg_sp(dbg_sp),
        .trc_valid(trc_valid), .trc_write(trc_write), .trc_addr(trc_addr), .trc_data(trc_data),
        .trc_retire(trc_retire), .trc_pc(trc_pc)
    );

    // 4 KiB memory image, address bits 11:0 select the byte
    logic [7:0] mem [0:4095];
    logic [7:0] ref_mem [0:4095];
    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int idle_bus = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct {
        logic [15:0] addr;
        bit          wr;
        logic [7:0]  data;
        bit          ret;
        logic [15:0] pc;
        string       tag;
    } ev_t;
    ev_t exp_q[$];

    logic [15:0] r_pc, r_ipc;
    logic [7:0]  r_a, r_p, r_op;
    bit          r_ill;

    task automatic push(input logic [15:0] a, input bit w, input logic [7:0] d,
                        input bit rt, input logic [15:0] p, input string t);
        ev_t e;
        e.addr = a; e.wr = w; e.data = d; e.ret = rt; e.pc = p; e.tag = t;
        exp_q.push_back(e);
    endtask

    task automatic ref_fetch_next(input string t, input bit rt);
        push(r_pc, 1'b0, ref_mem[r_pc[11:0]], rt, rt ? r_ipc : 16'h0, t);
        r_op  = ref_mem[r_pc[11:0]];
        r_ipc = r_pc;
        r_pc  = r_pc + 16'd1;
    endtask

    task automatic ref_boot();
        push(16'hFFFC, 1'b0, ref_mem[12'hFFC], 1'b0, 16'h0, "R1");
        push(16'hFFFD, 1'b0, ref_mem[12'hFFD], 1'b0, 16'h0, "R1");
        r_pc = {ref_mem[12'hFFD], ref_mem[12'hFFC]};
        r_a = 8'h00; r_p = 8'h24; r_ill = 1'b0;
        ref_fetch_next("R1", 1'b0);
    endtask

    task automatic ref_instr();
        logic [7:0]  lo, hi;
        logic [15:0] ea;
        case (r_op)
            8'hA9: begin
                lo = ref_mem[r_pc[11:0]];
                push(r_pc, 1'b0, lo, 1'b0, 16'h0, "R2");
                r_pc = r_pc + 16'd1;
                ref_fetch_next("R7", 1'b1);
                r_a = lo;
                r_p[7] = lo[7];
                r_p[1] = (lo == 8'h00);
            end
            8'h85: begin
                lo = ref_mem[r_pc[11:0]];
                push(r_pc, 1'b0, lo, 1'b0, 16'h0, "R4");
                push(r_pc, 1'b0, lo, 1'b0, 16'h0, "R4");
                r_pc = r_pc + 16'd1;
                ea = {8'h00, lo};
                push(ea, 1'b1, r_a, 1'b0, 16'h0, "R4");
                ref_mem[ea[11:0]] = r_a;
                ref_fetch_next("R7", 1'b1);
            end
            8'h8D: begin
                lo = ref_mem[r_pc[11:0]];
                push(r_pc, 1'b0, lo, 1'b0, 16'h0, "R5");
                r_pc = r_pc + 16'd1;
                hi = ref_mem[r_pc[11:0]];
                push(r_pc, 1'b0, hi, 1'b0, 16'h0, "R5");
                push(r_pc, 1'b0, hi, 1'b0, 16'h0, "R5");
                r_pc = r_pc + 16'd1;
                ea = {hi, lo};
                push(ea, 1'b1, r_a, 1'b0, 16'h0, "R5");
                ref_mem[ea[11:0]] = r_a;
                ref_fetch_next("R7", 1'b1);
            end
            8'h4C: begin
                lo = ref_mem[r_pc[11:0]];
                push(r_pc, 1'b0, lo, 1'b0, 16'h0, "R6");
                r_pc = r_pc + 16'd1;
                hi = ref_mem[r_pc[11:0]];
                push(r_pc, 1'b0, hi, 1'b0, 16'h0, "R6");
                r_pc = {hi, lo};
                ref_fetch_next("R6", 1'b1);
            end
            default: r_ill = 1'b1;
        endcase
    endtask

    // ---------------- per-clock comparison ----------------
    always @(negedge clk) begin
        if (!rst && !done) begin
            cycles++;
            if (trc_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected bus cycle addr", int'(trc_addr), 0);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    chk(trc_addr == e.addr && mem_addr == e.addr, e.tag, "bus address",
                        int'(trc_addr), int'(e.addr));
                    chk(trc_write == e.wr && mem_we == e.wr, e.tag, "write flag",
                        int'(trc_write), int'(e.wr));
                    chk(trc_data == e.data, e.tag, "bus data", int'(trc_data), int'(e.data));
                    chk(trc_retire == e.ret, "R8", "retire strobe", int'(trc_retire), int'(e.ret));
                    if (e.ret)
                        chk(trc_pc == e.pc, "R8", "retire pc", int'(trc_pc), int'(e.pc));
                end
            end else begin
                idle_bus++;
                if (trc_retire) chk(1'b0, "R8", "retire without bus cycle", 1, 0);
            end
        end
    end

    task automatic wait_halted(input string req);
        int n = 0;
        @(negedge clk);
        while (!dbg_halted && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(dbg_halted, req, "core halted", int'(dbg_halted), 1);
    endtask

    task automatic pulse_step();
        dbg_step = 1'b1;
        @(negedge clk);
        dbg_step = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        finish_run();
    end

    initial begin
        int idle0;
        for (int i = 0; i < 4096; i++) mem[i] = 8'hEA;
        mem[12'hFFC] = 8'h00; mem[12'hFFD] = 8'hF4;
        mem[12'h020] = 8'h55; mem[12'h021] = 8'h55; mem[12'hC0D] = 8'h55;
        // F400: A9 00 / 85 20 / A9 91 / 8D 0D DC / A9 7F / 4C 00 F5
        mem[12'h400] = 8'hA9; mem[12'h401] = 8'h00;
        mem[12'h402] = 8'h85; mem[12'h403] = 8'h20;
        mem[12'h404] = 8'hA9; mem[12'h405] = 8'h91;
        mem[12'h406] = 8'h8D; mem[12'h407] = 8'h0D; mem[12'h408] = 8'hDC;
        mem[12'h409] = 8'hA9; mem[12'h40A] = 8'h7F;
        mem[12'h40B] = 8'h4C; mem[12'h40C] = 8'h00; mem[12'h40D] = 8'hF5;
        // F500: A9 80 / 85 21 / 02 (unknown)
        mem[12'h500] = 8'hA9; mem[12'h501] = 8'h80;
        mem[12'h502] = 8'h85; mem[12'h503] = 8'h21;
        mem[12'h504] = 8'h02;
        for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];

        ref_boot();
        for (int k = 0; k < 20 && !r_ill; k++) ref_instr();

        repeat (3) @(negedge clk);
        // R11 reset state
        chk(dbg_a == 8'h00, "R11", "A at reset", int'(dbg_a), 0);
        chk(dbg_x == 8'h00 && dbg_y == 8'h00 && dbg_z == 8'h00, "R11", "X|Y|Z at reset",
            int'(dbg_x | dbg_y | dbg_z), 0);
        chk(dbg_p == 8'h24, "R11", "P at reset", int'(dbg_p), 'h24);
        chk(dbg_sp == 16'h01FF, "R11", "SP at reset", int'(dbg_sp), 'h1FF);
        chk(!dbg_illegal, "R10", "illegal flag at reset", int'(dbg_illegal), 0);
        rst = 1'b0;

        // R1 boot then halt with run low (R9)
        wait_halted("R1");
        chk(exp_q.size() > 0 && exp_q[0].addr == 16'hF401, "R1", "boot consumed vector and first fetch",
            exp_q.size() > 0 ? int'(exp_q[0].addr) : 0, 'hF401);

        // R9 halted: no bus activity over several cycles
        idle0 = idle_bus;
        repeat (8) @(negedge clk);
        chk(idle_bus - idle0 == 8, "R9", "idle cycles while halted", idle_bus - idle0, 8);

        // step 1: lda #$00
        pulse_step();
        wait_halted("R9");
        chk(dbg_a == 8'h00, "R2", "A after lda #00", int'(dbg_a), 0);
        chk(dbg_p == 8'h26, "R3", "P after zero load", int'(dbg_p), 'h26);
        chk(exp_q.size() > 0 && exp_q[0].addr == 16'hF403, "R9", "one instruction per step",
            exp_q.size() > 0 ? int'(exp_q[0].addr) : 0, 'hF403);

        // step 2: sta $20
        pulse_step();
        wait_halted("R9");
        chk(mem[12'h020] == 8'h00, "R4", "zero-page store", int'(mem[12'h020]), 0);

        // free run to the unknown opcode
        dbg_run = 1'b1;
        begin
            int n = 0;
            while (!dbg_illegal && n < 400) begin
                @(negedge clk);
                n++;
            end
        end
        dbg_run = 1'b0;
        chk(dbg_illegal, "R10", "illegal flag set", int'(dbg_illegal), 1);
        chk(dbg_halted, "R10", "halted on illegal", int'(dbg_halted), 1);
        chk(mem[12'hC0D] == 8'h91, "R5", "absolute store", int'(mem[12'hC0D]), 'h91);
        chk(mem[12'h021] == 8'h80, "R6", "store after jump target", int'(mem[12'h021]), 'h80);
        chk(dbg_a == 8'h80, "R2", "final A", int'(dbg_a), 'h80);
        chk(dbg_p == 8'hA4 && dbg_p == r_p, "R3", "P after negative load", int'(dbg_p), 'hA4);
        chk(exp_q.size() == 0, "R7", "expected events left over", exp_q.size(), 0);

        // R10: run and step have no effect now
        dbg_run = 1'b1;
        repeat (5) @(negedge clk);
        dbg_run = 1'b0;
        pulse_step();
        idle0 = idle_bus;
        repeat (6) @(negedge clk);
        chk(idle_bus - idle0 == 6, "R10", "bus idle after illegal", idle_bus - idle0, 6);
        chk(dbg_illegal && dbg_a == 8'h80, "R10", "flag and A held", int'(dbg_a), 'h80);

        finish_run();
    end

endmodule